// File: doc/BRIEF.md
# Sectored Tag Directory

This block keeps the tags for an inclusive cache level whose blocks are larger than the lines of the cache below it. Each block is split into sectors, and each sector is exactly one lower-level line wide. One tag serves a whole block. Every sector carries its own two-bit coherence state, so presence and ownership are tracked per sector while the tag cost is paid once per block.

A request carries a line address made of tag, set index and sector index, from most significant to least significant. Lookups get their answer in the same cycle: tag match, sector hit, way and sector state. Fills install one sector at a time, either into an entry whose tag already matches or into a newly allocated way. Writes move a held sector to modified. A write to a shared sector raises an upgrade request for the coherence engine, which sits outside this block.

When an allocation displaces a block that still holds valid sectors, the block walks that victim. It sends a back-invalidate to the lower level for each valid sector, and it sends a writeback first for each modified one. Data storage is not part of this block.

Top module: `sdir_top`

## Requirements
- R1: After reset every sector of every way is invalid, so every lookup reports no tag match and no hit, and `busy` and `evt_valid` are low.
- R2: In the cycle of a request, `rsp_tag_hit` is set when a way of the addressed set holds the request tag and has at least one non-invalid sector, and `rsp_way` names the lowest such way. `rsp_hit` is set only when the addressed sector of that way is not invalid. A tag match on an invalid sector is a miss.
- R3: A fill (`req_op` 2'b01) whose tag matches writes `req_state` into the addressed sector only. The other sectors keep their states, and no eviction occurs.
- R4: A fill without a tag match allocates the lowest way whose sectors are all invalid, or the replacement victim if none is free. It stores the tag, sets the addressed sector to `req_state` and sets all other sectors of that way invalid.
- R5: Replacement is least-recently-used per set. A way is touched by a fill into it, and by a lookup (2'b00) or write (2'b10) that hits it.
- R6: A write that hits a sector in exclusive or modified state makes it modified with `upg_req` low. A write that hits a shared sector makes it modified and raises `upg_req` in the request cycle. A write that misses changes nothing.
- R7: Displacing a victim with valid sectors produces, from the cycle after the fill, one event per cycle on `evt_*`. In ascending sector order, each valid sector gives one back-invalidate (`evt_wb` 0). A modified sector gives a writeback (`evt_wb` 1) in the cycle just before its invalidate. `evt_addr` is the victim tag, set and sector. Invalid sectors produce nothing.
- R8: `busy` is high exactly while eviction events remain. Requests presented while `busy` is high are ignored and change no state.
- R9: Sector states are encoded as 2'b00 invalid, 2'b01 shared, 2'b10 exclusive and 2'b11 modified on `req_state` and `rsp_state`. `rsp_state` is 2'b00 when there is no tag match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 00 lookup, 01 fill, 10 write |
| req_addr | input | TAG_W+log2(SETS)+log2(SECTORS) | {tag, set, sector} line address |
| req_state | input | 2 | Sector state installed by a fill |
| rsp_hit | output | 1 | Addressed sector present |
| rsp_tag_hit | output | 1 | Tag present in the set |
| rsp_way | output | log2(WAYS) | Way of the tag match |
| rsp_state | output | 2 | State of the addressed sector |
| upg_req | output | 1 | Write to a shared sector needs an upgrade |
| busy | output | 1 | Eviction walk in progress |
| evt_valid | output | 1 | Eviction event present |
| evt_wb | output | 1 | 1 writeback, 0 back-invalidate |
| evt_addr | output | TAG_W+log2(SETS)+log2(SECTORS) | Line address of the event |

## Verification
A wrong sector state shows up on `rsp_state` and `rsp_hit` at the next lookup of that sector. It can also appear many requests later as a missing or extra writeback when the block is displaced. A corrupted recency order stays hidden until a full set must choose a victim, and then the wrong block's address shows on `evt_addr` in the cycle after the fill. For these reasons the bench runs a long mixed sweep over a few sets and a handful of colliding tags. It compares every response in its own cycle and every event in its own cycle against an arithmetic model of the directory.

// File: rtl/sdir_pkg.sv
package sdir_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } sec_state_e;

  typedef enum logic [1:0] {
    OP_LOOKUP = 2'b00,
    OP_FILL   = 2'b01,
    OP_WRITE  = 2'b10
  } dir_op_e;
endpackage

// File: rtl/sdir_array.sv
module sdir_array #(
  parameter  int TAG_W   = 20,
  parameter  int SETS    = 64,
  parameter  int WAYS    = 4,
  parameter  int SECTORS = 2,
  localparam int SET_W   = $clog2(SETS),
  localparam int WAY_W   = $clog2(WAYS)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [SET_W-1:0]                  rd_set,
  output logic [WAYS-1:0][TAG_W-1:0]        rd_tag,
  output logic [WAYS-1:0][SECTORS-1:0][1:0] rd_st,
  input  logic                              wr_en,
  input  logic [SET_W-1:0]                  wr_set,
  input  logic [WAY_W-1:0]                  wr_way,
  input  logic                              wr_tag_en,
  input  logic [TAG_W-1:0]                  wr_tag,
  input  logic [SECTORS-1:0][1:0]           wr_st
);
  logic [WAYS-1:0][TAG_W-1:0]        tag_q [SETS];
  logic [WAYS-1:0][SECTORS-1:0][1:0] st_q  [SETS];

  // state bits are reset; tags are plain storage qualified by state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) st_q[s] <= '0;
    end else if (wr_en) begin
      st_q[wr_set][wr_way] <= wr_st;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_tag_en) tag_q[wr_set][wr_way] <= wr_tag;
  end

  assign rd_tag = tag_q[rd_set];
  assign rd_st  = st_q[rd_set];
endmodule

// File: rtl/sdir_lru.sv
module sdir_lru #(
  parameter  int SETS  = 64,
  parameter  int WAYS  = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] set_idx,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] victim_way
);
  logic [WAYS-1:0][WAY_W-1:0] age_q [SETS];
  logic [WAYS-1:0][WAY_W-1:0] row_cur, row_nxt;

  assign row_cur = age_q[set_idx];

  // touched way becomes youngest; younger ways age by one
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      if (WAY_W'(w) == touch_way)            row_nxt[w] = '0;
      else if (row_cur[w] < row_cur[touch_way]) row_nxt[w] = row_cur[w] + 1'b1;
      else                                    row_nxt[w] = row_cur[w];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch_en) begin
      age_q[set_idx] <= row_nxt;
    end
  end

  always_comb begin
    victim_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (row_cur[w] == WAY_W'(WAYS - 1)) victim_way = WAY_W'(w);
  end
endmodule

// File: rtl/sdir_evict.sv
module sdir_evict import sdir_pkg::*; #(
  parameter  int TAG_W   = 20,
  parameter  int SET_W   = 6,
  parameter  int SECTORS = 2,
  localparam int SEC_W   = $clog2(SECTORS),
  localparam int ADDR_W  = TAG_W + SET_W + SEC_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [TAG_W-1:0]        ld_tag,
  input  logic [SET_W-1:0]        ld_set,
  input  logic [SECTORS-1:0][1:0] ld_st,
  output logic                    evt_valid,
  output logic                    evt_wb,
  output logic [ADDR_W-1:0]       evt_addr
);
  logic [TAG_W-1:0]        tag_q;
  logic [SET_W-1:0]        set_q;
  logic [SECTORS-1:0][1:0] st_q, st_d;
  logic                    wb_q, wb_d;
  logic [SEC_W-1:0]        cur;
  logic                    any;

  // lowest sector still holding a state
  always_comb begin
    any = 1'b0;
    cur = '0;
    for (int s = SECTORS - 1; s >= 0; s--)
      if (st_q[s] != ST_I) begin
        any = 1'b1;
        cur = SEC_W'(s);
      end
  end

  assign evt_valid = any;
  assign evt_wb    = any && (st_q[cur] == ST_M) && !wb_q;
  assign evt_addr  = {tag_q, set_q, cur};

  always_comb begin
    st_d = st_q;
    wb_d = wb_q;
    if (load) begin
      st_d = ld_st;
      wb_d = 1'b0;
    end else if (any) begin
      if (evt_wb) wb_d = 1'b1;
      else begin
        st_d[cur] = ST_I;
        wb_d      = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      wb_q <= 1'b0;
    end else begin
      st_q <= st_d;
      wb_q <= wb_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      tag_q <= ld_tag;
      set_q <= ld_set;
    end
  end
endmodule

// File: rtl/sdir_top.sv
module sdir_top import sdir_pkg::*; #(
  parameter  int TAG_W   = 20,
  parameter  int SETS    = 64,
  parameter  int WAYS    = 4,
  parameter  int SECTORS = 2,
  localparam int SET_W   = $clog2(SETS),
  localparam int WAY_W   = $clog2(WAYS),
  localparam int SEC_W   = $clog2(SECTORS),
  localparam int ADDR_W  = TAG_W + SET_W + SEC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_state,
  output logic              rsp_hit,
  output logic              rsp_tag_hit,
  output logic [WAY_W-1:0]  rsp_way,
  output logic [1:0]        rsp_state,
  output logic              upg_req,
  output logic              busy,
  output logic              evt_valid,
  output logic              evt_wb,
  output logic [ADDR_W-1:0] evt_addr
);
  logic [SEC_W-1:0]                  req_sec;
  logic [SET_W-1:0]                  req_set;
  logic [TAG_W-1:0]                  req_tag;
  logic [WAYS-1:0][TAG_W-1:0]        rd_tag;
  logic [WAYS-1:0][SECTORS-1:0][1:0] rd_st;
  logic [SECTORS-1:0][1:0]           cur_row, wr_st;
  logic [WAYS-1:0]                   match;
  logic [WAY_W-1:0]                  hit_way, free_way, lru_way, alloc_way, wr_way;
  logic                              has_free, accept, do_fill, do_write, do_look;
  logic                              wr_en, wr_tag_en, ev_load;

  assign req_sec = req_addr[SEC_W-1:0];
  assign req_set = req_addr[SEC_W +: SET_W];
  assign req_tag = req_addr[ADDR_W-1 -: TAG_W];

  sdir_array #(.TAG_W(TAG_W), .SETS(SETS), .WAYS(WAYS), .SECTORS(SECTORS)) u_array (
    .clk(clk), .rst_n(rst_n), .rd_set(req_set), .rd_tag(rd_tag), .rd_st(rd_st),
    .wr_en(wr_en), .wr_set(req_set), .wr_way(wr_way), .wr_tag_en(wr_tag_en),
    .wr_tag(req_tag), .wr_st(wr_st)
  );

  sdir_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk(clk), .rst_n(rst_n), .set_idx(req_set),
    .touch_en(do_fill || do_write || do_look), .touch_way(wr_way), .victim_way(lru_way)
  );

  sdir_evict #(.TAG_W(TAG_W), .SET_W(SET_W), .SECTORS(SECTORS)) u_evict (
    .clk(clk), .rst_n(rst_n), .load(ev_load), .ld_tag(rd_tag[lru_way]),
    .ld_set(req_set), .ld_st(rd_st[lru_way]),
    .evt_valid(evt_valid), .evt_wb(evt_wb), .evt_addr(evt_addr)
  );

  // tag compare and free-way search, lowest index wins
  always_comb begin
    hit_way  = '0;
    free_way = '0;
    has_free = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      match[w] = (rd_tag[w] == req_tag) && (|rd_st[w]);
      if (match[w]) hit_way = WAY_W'(w);
      if (~|rd_st[w]) begin
        has_free = 1'b1;
        free_way = WAY_W'(w);
      end
    end
  end

  assign cur_row     = rd_st[hit_way];
  assign rsp_tag_hit = |match;
  assign rsp_way     = hit_way;
  assign rsp_state   = rsp_tag_hit ? cur_row[req_sec] : ST_I;
  assign rsp_hit     = rsp_state != ST_I;
  assign busy        = evt_valid;

  assign accept    = req_valid && !busy;
  assign do_fill   = accept && (req_op == OP_FILL);
  assign do_write  = accept && (req_op == OP_WRITE) && rsp_hit;
  assign do_look   = accept && (req_op == OP_LOOKUP) && rsp_hit;
  assign alloc_way = has_free ? free_way : lru_way;
  assign upg_req   = do_write && (rsp_state == ST_S);
  assign ev_load   = do_fill && !rsp_tag_hit && !has_free;

  // next-state of the addressed row
  always_comb begin
    wr_en     = 1'b0;
    wr_tag_en = 1'b0;
    wr_way    = hit_way;
    wr_st     = cur_row;
    if (do_fill && rsp_tag_hit) begin
      wr_en          = 1'b1;
      wr_st[req_sec] = req_state;
    end else if (do_fill) begin
      wr_en          = 1'b1;
      wr_tag_en      = 1'b1;
      wr_way         = alloc_way;
      wr_st          = '0;
      wr_st[req_sec] = req_state;
    end else if (do_write) begin
      wr_en          = 1'b1;
      wr_st[req_sec] = ST_M;
    end
  end
endmodule

// File: rtl/sdir_chk.sv
module sdir_chk #(
  parameter int ADDR_W = 27,
  parameter int SEC_W  = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_op,
  input logic              rsp_hit,
  input logic [1:0]        rsp_state,
  input logic              upg_req,
  input logic              busy,
  input logic              evt_valid,
  input logic              evt_wb,
  input logic [ADDR_W-1:0] evt_addr
);
  AST_WB_BEFORE_INV: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && evt_wb |=> evt_valid && !evt_wb && $stable(evt_addr)); // R7

  AST_SECTOR_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && $past(evt_valid) && !$past(evt_wb)
      |-> evt_addr[SEC_W-1:0] > $past(evt_addr[SEC_W-1:0])); // R7

  AST_VICTIM_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && $past(evt_valid)
      |-> evt_addr[ADDR_W-1:SEC_W] == $past(evt_addr[ADDR_W-1:SEC_W])); // R7

  AST_UPG_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    upg_req |-> rsp_hit && rsp_state == 2'b01 && req_op == 2'b10); // R6

  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !upg_req); // R8

  AST_EVT_FROM_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_valid) |-> $past(req_valid && req_op == 2'b01 && !busy)); // R4
endmodule

bind sdir_top sdir_chk #(.ADDR_W(ADDR_W), .SEC_W(SEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .rsp_hit(rsp_hit), .rsp_state(rsp_state), .upg_req(upg_req), .busy(busy),
  .evt_valid(evt_valid), .evt_wb(evt_wb), .evt_addr(evt_addr)
);

// File: tb/sim_sdir_top.sv
module sim_sdir_top;
  localparam int TW = 4, NS = 4, NW = 4, NSEC = 2;
  localparam int AW = TW + 2 + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          req_valid = 1'b0;
  logic [1:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_state = '0;
  logic          rsp_hit, rsp_tag_hit, upg_req, busy, evt_valid, evt_wb;
  logic [1:0]    rsp_way, rsp_state;
  logic [AW-1:0] evt_addr;

  sdir_top #(.TAG_W(TW), .SETS(NS), .WAYS(NW), .SECTORS(NSEC)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_state(req_state), .rsp_hit(rsp_hit),
    .rsp_tag_hit(rsp_tag_hit), .rsp_way(rsp_way), .rsp_state(rsp_state),
    .upg_req(upg_req), .busy(busy), .evt_valid(evt_valid), .evt_wb(evt_wb),
    .evt_addr(evt_addr)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  int mtag[NS][NW];
  int mst[NS][NW][NSEC];
  int mage[NS][NW];
  int ev_n;
  int ev_wb[8];
  int ev_addr[8];
  int l_hit, l_thit, l_st, l_way, l_upg;

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", r, act, exp);
    end
  endtask

  function automatic int anyv(input int s, input int w);
    int r = 0;
    for (int k = 0; k < NSEC; k++) if (mst[s][w][k] != 0) r = 1;
    return r;
  endfunction

  task automatic touch(input int s, input int w);
    int a = mage[s][w];
    for (int k = 0; k < NW; k++) if (mage[s][k] < a) mage[s][k]++;
    mage[s][w] = 0;
  endtask

  // drive one request, compare response, update model, follow events
  task automatic do_op(input int op, input int tag, input int set, input int sec,
                       input int st, input int poke);
    int thit = 0, hw = 0, hst, fw, vic = 0;
    req_valid = 1'b1;
    req_op    = 2'(op);
    req_addr  = AW'((tag << 3) | (set << 1) | sec);
    req_state = 2'(st);
    for (int w = NW - 1; w >= 0; w--)
      if (mtag[set][w] == tag && anyv(set, w) != 0) begin thit = 1; hw = w; end
    hst = thit ? mst[set][hw][sec] : 0;
    #1;
    chk("R2 tag match", int'(rsp_tag_hit), thit);
    chk("R2 sector hit", int'(rsp_hit), int'(hst != 0));
    chk("R9 state code", int'(rsp_state), hst);
    if (thit != 0) chk("R2 way", int'(rsp_way), hw);
    chk("R6 upgrade", int'(upg_req), int'(op == 2 && hst == 1));
    l_hit = int'(rsp_hit); l_thit = int'(rsp_tag_hit); l_st = int'(rsp_state);
    l_way = int'(rsp_way); l_upg = int'(upg_req);
    @(posedge clk); #2;
    req_valid = 1'b0;
    ev_n = 0;
    if (op == 1) begin
      if (thit != 0) begin
        mst[set][hw][sec] = st;
        touch(set, hw);
      end else begin
        fw = -1;
        for (int w = NW - 1; w >= 0; w--) if (anyv(set, w) == 0) fw = w;
        if (fw < 0) begin
          for (int w = 0; w < NW; w++) if (mage[set][w] == NW - 1) vic = w;
          for (int k = 0; k < NSEC; k++) begin
            if (mst[set][vic][k] == 3) begin
              ev_wb[ev_n] = 1; ev_addr[ev_n] = (mtag[set][vic] << 3) | (set << 1) | k; ev_n++;
            end
            if (mst[set][vic][k] != 0) begin
              ev_wb[ev_n] = 0; ev_addr[ev_n] = (mtag[set][vic] << 3) | (set << 1) | k; ev_n++;
            end
          end
          fw = vic;
        end
        mtag[set][fw] = tag;
        for (int k = 0; k < NSEC; k++) mst[set][fw][k] = 0;
        mst[set][fw][sec] = st;
        touch(set, fw);
      end
    end else if (op == 2 && hst != 0) begin
      mst[set][hw][sec] = 3;
      touch(set, hw);
    end else if (op == 0 && hst != 0) begin
      touch(set, hw);
    end
    for (int i = 0; i < ev_n; i++) begin
      chk("R7 event present", int'(evt_valid), 1);
      chk("R7 event kind", int'(evt_wb), ev_wb[i]);
      chk("R7 event address", int'(evt_addr), ev_addr[i]);
      chk("R8 busy during walk", int'(busy), 1);
      if (poke != 0 && i == 0) begin
        req_valid = 1'b1; req_op = 2'b01; req_addr = AW'((3 << 3) | (2 << 1)); req_state = 2'b10;
      end
      @(posedge clk); #2;
      req_valid = 1'b0;
    end
    chk("R8 busy idle", int'(busy), 0);
    chk("R7 no extra event", int'(evt_valid), 0);
  endtask

  initial begin
    int seed = 12345;
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        mtag[s][w] = 0; mage[s][w] = w;
        for (int k = 0; k < NSEC; k++) mst[s][w][k] = 0;
      end
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(posedge clk); #2;
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 no event after reset", int'(evt_valid), 0);
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < NSEC; k++) begin
        do_op(0, 0, s, k, 0, 0);
        chk("R1 lookup misses", l_hit + l_thit, 0);
      end
    // R3: second sector fill keeps the first
    do_op(1, 5, 1, 0, 2, 0);
    do_op(1, 5, 1, 1, 1, 0);
    chk("R3 no eviction", ev_n, 0);
    do_op(0, 5, 1, 0, 0, 0);
    chk("R3 first sector kept", l_st, 2);
    // R4: new tag takes next free way, other sector invalid
    do_op(1, 6, 1, 1, 3, 0);
    do_op(0, 6, 1, 0, 0, 0);
    chk("R4 tag match", l_thit, 1);
    chk("R4 other sector invalid", l_hit, 0);
    chk("R4 free way chosen", l_way, 1);
    // R6: exclusive write silent, shared write upgrades
    do_op(2, 5, 1, 0, 0, 0);
    chk("R6 exclusive write silent", l_upg, 0);
    do_op(0, 5, 1, 0, 0, 0);
    chk("R6 exclusive becomes modified", l_st, 3);
    do_op(2, 5, 1, 1, 0, 0);
    chk("R6 shared write upgrades", l_upg, 1);
    do_op(0, 5, 1, 1, 0, 0);
    chk("R6 shared becomes modified", l_st, 3);
    do_op(2, 9, 1, 0, 0, 0);
    chk("R6 write miss no upgrade", l_upg, 0);
    // R5, R7, R8: fill set, refresh tag 5, displace tag 6 with a poke during walk
    do_op(1, 7, 1, 0, 1, 0);
    do_op(1, 8, 1, 0, 2, 0);
    do_op(0, 5, 1, 0, 0, 0);
    do_op(1, 9, 1, 0, 2, 1);
    chk("R7 modified victim gives two events", ev_n, 2);
    do_op(0, 6, 1, 1, 0, 0);
    chk("R5 least recent evicted", l_thit, 0);
    do_op(0, 5, 1, 0, 0, 0);
    chk("R5 recent entry kept", l_hit, 1);
    do_op(0, 3, 2, 0, 0, 0);
    chk("R8 request while busy ignored", l_thit, 0);
    // mixed sweep
    for (int n = 0; n < 3000; n++) begin
      int r, op;
      seed = seed * 1103515245 + 12345;
      r = (seed >>> 8) & 32'h7fffff;
      op = (r % 20 < 8) ? 1 : ((r % 20 < 15) ? 0 : 2);
      do_op(op, (r / 20) % 6, (r / 120) % NS, (r / 480) % NSEC, (r / 960) % 4, 0);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1900000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule